// File: doc/BRIEF.md
# Mixed-depth pixel source selector

This block sits in a display pipeline after three plane fetchers that deliver, for one screen position, an 8-bit palette index, a 32-bit true-colour word and a 32-bit control word. For every pixel it picks one of two colour sources. It uses the stored true-colour value directly when the pixel's control word asks for it. Otherwise it sends the index to an external palette memory and passes on the colour that comes back.

Pixels enter and leave through valid/ready streams at one pixel per beat. The palette memory is a synchronous read port with one cycle of latency. The true-colour path is therefore registered for one stage, so that both sources reach the output in the same cycle. A three-state stage controller handles back-pressure from the output. Its states are `ST_EMPTY` (no pixel held), `ST_LOOKUP` (a pixel accepted on the last edge; a palette colour, if any, arrives this cycle) and `ST_HOLD` (a stalled pixel whose colour has been captured locally). Its transitions are named take (EMPTY→LOOKUP), stream (LOOKUP→LOOKUP), drain (LOOKUP→EMPTY), stall (LOOKUP→HOLD), wait (HOLD→HOLD), refill (HOLD→LOOKUP) and release (HOLD→EMPTY). Because of `ST_HOLD`, the palette port never has to keep its read data stable while the output is blocked.

Top module: `pix_source_sel`

## Requirements
- R1: While reset is held and on the first cycle after it, `m_valid` and `pal_rd_en` are 0 and `s_ready` is 1.
- R2: A pixel whose `s_ctrl[31:24]` equals 8'h03 is output as true colour. The true-colour word holds blue in bits 23:16, green in 15:8 and red in 7:0. The output `m_rgb` carries red in 23:16, green in 15:8 and blue in 7:0.
- R3: A pixel with any other value in `s_ctrl[31:24]` is output as the palette colour read at address `s_index`. `s_ctrl[23:0]` never affects the choice.
- R4: Bits 31:24 of `s_direct` never affect the output colour.
- R5: `pal_rd_en` is 1, with `pal_addr` equal to `s_index`, exactly in those cycles where an indexed pixel is accepted (`s_valid` and `s_ready` both 1). In every other cycle, including the acceptance of a true-colour pixel, it is 0.
- R6: A pixel accepted at a clock edge is presented with `m_valid` high in the cycle right after that edge. While `m_ready` stays high, one pixel is accepted on every cycle.
- R7: While `m_valid` is 1 and `m_ready` is 0, `m_valid` and `m_rgb` hold their values on the following edge.
- R8: Every accepted pixel is output exactly once, in order, under any pattern of back-pressure.
- R9: `s_ready` is 1 exactly when the stage is empty or `m_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted when high together with s_valid |
| s_index | input | 8 | Indexed-plane value for the pixel |
| s_direct | input | 32 | True-colour plane word (blue, green, red in bits 23:0) |
| s_ctrl | input | 32 | Control-plane word; bits 31:24 hold the source code |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream can take the output pixel |
| m_rgb | output | 24 | Output colour, red in 23:16, green 15:8, blue 7:0 |
| pal_rd_en | output | 1 | Palette read strobe |
| pal_addr | output | 8 | Palette read address |
| pal_data | input | 24 | Palette colour, valid one cycle after the read strobe |

## Verification
The palette read strobe and address must appear in the same cycle as the acceptance. Colour, valid and the stall hold are due one clock edge later. A stalled pixel must then stay unchanged for every further cycle that `m_ready` stays low. The bench drives inputs and sets `m_ready` on the falling edge. A quarter period later, with every input and output settled for the next rising edge, the driver checks the palette strobe and the monitor checks the output side. The monitor compares each delivered pixel against a queue of colours computed when the pixel was accepted. It also compares `m_valid` and `m_rgb` with what it saw one sample earlier, so that the one-edge latency and the stall hold are checked exactly at the cycle where they are due.

// File: rtl/pxsel_pkg.sv
package pxsel_pkg;

    // Occupancy of the single output stage.
    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,   // nothing held
        ST_LOOKUP = 2'd1,   // accepted last edge, palette data on its way in
        ST_HOLD   = 2'd2    // stalled pixel, colour captured locally
    } stage_state_e;

endpackage

// File: rtl/pxsel_decode.sv
// Classifies a pixel by its control code and reorders the true-colour
// channels from stored (blue high, red low) into output (red high) order.
module pxsel_decode #(
    parameter int CH_W        = 8,
    parameter int WORD_W      = 4 * CH_W,
    parameter int DIRECT_CODE = 3
) (
    input  logic [WORD_W-1:0]   direct_word,
    input  logic [WORD_W-1:0]   ctrl_word,
    output logic                is_direct,
    output logic [3*CH_W-1:0]   rgb_direct
);
    localparam int NCH    = 3;
    localparam int CODE_W = WORD_W - NCH * CH_W;

    logic [CODE_W-1:0] mode_code;
    assign mode_code = ctrl_word[WORD_W-1 -: CODE_W];
    assign is_direct = (mode_code == CODE_W'(DIRECT_CODE));

    // Channel c of the stored word lands in slot NCH-1-c of the output.
    for (genvar c = 0; c < NCH; c++) begin : g_swap
        assign rgb_direct[(NCH-1-c)*CH_W +: CH_W] = direct_word[c*CH_W +: CH_W];
    end

    // Bits that take no part in the decision are deliberately left out.
    logic unused_bits;
    assign unused_bits = ^{ctrl_word[WORD_W-CODE_W-1:0], direct_word[WORD_W-1 -: CODE_W]};

endmodule

// File: rtl/pxsel_stage.sv
// One-deep output stage aligning the registered true-colour path with the
// one-cycle palette read, and absorbing output back-pressure.
module pxsel_stage
    import pxsel_pkg::*;
#(
    parameter int RGB_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_fire,
    input  logic             in_direct,
    input  logic [RGB_W-1:0] in_rgb,
    input  logic [RGB_W-1:0] pal_data,
    input  logic             m_ready,
    output logic             m_valid,
    output logic [RGB_W-1:0] m_rgb,
    output logic             take_ok
);
    stage_state_e state_q, state_d;
    logic             dir_q;
    logic [RGB_W-1:0] dir_rgb_q;
    logic [RGB_W-1:0] hold_rgb_q;
    logic [RGB_W-1:0] lookup_rgb;

    assign lookup_rgb = dir_q ? dir_rgb_q : pal_data;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  if (in_fire) state_d = ST_LOOKUP;          // take
            ST_LOOKUP: begin
                if (!m_ready)     state_d = ST_HOLD;              // stall
                else if (in_fire) state_d = ST_LOOKUP;            // stream
                else              state_d = ST_EMPTY;             // drain
            end
            ST_HOLD: begin
                if (!m_ready)     state_d = ST_HOLD;              // wait
                else if (in_fire) state_d = ST_LOOKUP;            // refill
                else              state_d = ST_EMPTY;             // release
            end
            default:              state_d = ST_EMPTY;
        endcase
    end

    // Output logic
    always_comb begin
        m_valid = 1'b0;
        m_rgb   = hold_rgb_q;
        take_ok = 1'b1;
        unique case (state_q)
            ST_EMPTY:  begin m_valid = 1'b0; take_ok = 1'b1; end
            ST_LOOKUP: begin m_valid = 1'b1; m_rgb = lookup_rgb; take_ok = m_ready; end
            ST_HOLD:   begin m_valid = 1'b1; m_rgb = hold_rgb_q; take_ok = m_ready; end
            default:   begin m_valid = 1'b0; take_ok = 1'b1; end
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q      <= 1'b0;
            dir_rgb_q  <= '0;
            hold_rgb_q <= '0;
        end else begin
            if (in_fire) begin
                dir_q     <= in_direct;
                dir_rgb_q <= in_rgb;
            end
            if (state_q == ST_LOOKUP && !m_ready)
                hold_rgb_q <= lookup_rgb;
        end
    end

    // R7: a blocked pixel keeps its colour and its valid flag
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_rgb)));

    // R6: an accepted pixel is presented on the next cycle
    assert_valid_after_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire |=> m_valid);

endmodule

// File: rtl/pix_source_sel.sv
// Per-pixel choice between true colour and palette colour.
module pix_source_sel #(
    parameter int CH_W        = 8,
    parameter int IDX_W       = 8,
    parameter int DIRECT_CODE = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_valid,
    output logic                 s_ready,
    input  logic [IDX_W-1:0]     s_index,
    input  logic [4*CH_W-1:0]    s_direct,
    input  logic [4*CH_W-1:0]    s_ctrl,
    output logic                 m_valid,
    input  logic                 m_ready,
    output logic [3*CH_W-1:0]    m_rgb,
    output logic                 pal_rd_en,
    output logic [IDX_W-1:0]     pal_addr,
    input  logic [3*CH_W-1:0]    pal_data
);
    localparam int WORD_W = 4 * CH_W;
    localparam int RGB_W  = 3 * CH_W;

    logic             is_direct;
    logic [RGB_W-1:0] rgb_direct;
    logic             take_ok;
    logic             fire;

    pxsel_decode #(
        .CH_W        (CH_W),
        .WORD_W      (WORD_W),
        .DIRECT_CODE (DIRECT_CODE)
    ) u_decode (
        .direct_word (s_direct),
        .ctrl_word   (s_ctrl),
        .is_direct   (is_direct),
        .rgb_direct  (rgb_direct)
    );

    assign s_ready   = take_ok;
    assign fire      = s_valid && take_ok;
    assign pal_addr  = s_index;
    assign pal_rd_en = fire && !is_direct;

    pxsel_stage #(
        .RGB_W (RGB_W)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_fire   (fire),
        .in_direct (is_direct),
        .in_rgb    (rgb_direct),
        .pal_data  (pal_data),
        .m_ready   (m_ready),
        .m_valid   (m_valid),
        .m_rgb     (m_rgb),
        .take_ok   (take_ok)
    );

    // R5: the palette is read only for an accepted indexed pixel
    assert_rd_only_indexed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pal_rd_en |-> (s_valid && s_ready &&
                       s_ctrl[WORD_W-1 -: WORD_W-RGB_W] != (WORD_W-RGB_W)'(DIRECT_CODE)));

    // R9: a blocked output closes the input
    assert_block_closes_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |-> !s_ready);

    // R2: a true-colour pixel leaves with its channels swapped into output order
    assert_direct_colour_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(s_valid && s_ready) &&
         $past(s_ctrl[WORD_W-1 -: WORD_W-RGB_W]) == (WORD_W-RGB_W)'(DIRECT_CODE))
        |-> (m_rgb == {$past(s_direct[CH_W-1:0]),
                       $past(s_direct[2*CH_W-1:CH_W]),
                       $past(s_direct[3*CH_W-1:2*CH_W])}));

endmodule

// File: tb/pix_source_sel_test.sv
module pix_source_sel_test;
    localparam int PERIOD   = 10;
    localparam int WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [7:0]  s_index = '0;
    logic [31:0] s_direct = '0;
    logic [31:0] s_ctrl = '0;
    logic        m_valid;
    logic        m_ready = 1'b1;
    logic [23:0] m_rgb;
    logic        pal_rd_en;
    logic [7:0]  pal_addr;
    logic [23:0] pal_q = '0;

    int checks = 0;
    int errors = 0;
    int cycle = 0;
    int wait_cycles = 0;
    bit stall_mode = 1'b0;
    bit done = 1'b0;

    logic [23:0] exp_q[$];
    string       tag_q[$];

    always #(PERIOD/2) clk = ~clk;

    pix_source_sel uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_valid   (s_valid),
        .s_ready   (s_ready),
        .s_index   (s_index),
        .s_direct  (s_direct),
        .s_ctrl    (s_ctrl),
        .m_valid   (m_valid),
        .m_ready   (m_ready),
        .m_rgb     (m_rgb),
        .pal_rd_en (pal_rd_en),
        .pal_addr  (pal_addr),
        .pal_data  (pal_q)
    );

    function automatic logic [23:0] pal_fn(input logic [7:0] a);
        return {a ^ 8'hA5, a + 8'd3, ~a};
    endfunction

    // Palette model: synchronous read, one cycle latency.
    always @(posedge clk) if (pal_rd_en) pal_q <= pal_fn(pal_addr);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cycle);
        end
    endtask

    always @(posedge clk) cycle++;

    // Downstream readiness
    always @(negedge clk) m_ready <= stall_mode ? ($urandom % 3 != 0) : 1'b1;

    // Driver: presents a pixel and pushes its expected colour on acceptance.
    task automatic send(input logic [7:0] idx, input logic [31:0] dw, input logic [31:0] cw,
                        input string tag);
        bit direct;
        direct = (cw[31:24] == 8'h03);
        @(negedge clk);
        s_valid = 1'b1; s_index = idx; s_direct = dw; s_ctrl = cw;
        forever begin
            #(PERIOD/4);
            if (s_ready) begin
                exp_q.push_back(direct ? {dw[7:0], dw[15:8], dw[23:16]} : pal_fn(idx));
                tag_q.push_back(tag);
                chk(pal_rd_en == !direct, "R5", {31'd0, pal_rd_en}, {31'd0, !direct});
                if (!direct) chk(pal_addr == idx, "R5", {24'd0, pal_addr}, {24'd0, idx});
                break;
            end
            wait_cycles++;
            chk(pal_rd_en == 1'b0, "R5", {31'd0, pal_rd_en}, 32'd0);
            @(negedge clk);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    // Monitor: compares delivered pixels and cycle-level rules.
    bit          prev_acc = 1'b0;
    bit          prev_stall = 1'b0;
    logic [23:0] prev_rgb = '0;
    always @(negedge clk) begin
        #(PERIOD/4);
        if (rst_n && !done) begin
            if (prev_acc) chk(m_valid == 1'b1, "R6", {31'd0, m_valid}, 32'd1);
            if (prev_stall) begin
                chk(m_valid == 1'b1, "R7", {31'd0, m_valid}, 32'd1);
                chk(m_rgb == prev_rgb, "R7", {8'd0, m_rgb}, {8'd0, prev_rgb});
            end
            chk(s_ready == (!m_valid || m_ready), "R9", {31'd0, s_ready},
                {31'd0, (!m_valid || m_ready)});
            if (!s_valid) chk(pal_rd_en == 1'b0, "R5", {31'd0, pal_rd_en}, 32'd0);
            if (m_valid && m_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", {8'd0, m_rgb}, 32'd0);
                end else begin
                    logic [23:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(m_rgb == e, t, {8'd0, m_rgb}, {8'd0, e});
                end
            end
            prev_acc   = s_valid && s_ready;
            prev_stall = m_valid && !m_ready;
            prev_rgb   = m_rgb;
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycle > WATCHDOG && !done) begin
            chk(1'b0, "watchdog", cycle, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #(PERIOD/4);
        // R1 while reset is held
        chk(m_valid == 1'b0, "R1", {31'd0, m_valid}, 32'd0);
        chk(s_ready == 1'b1, "R1", {31'd0, s_ready}, 32'd1);
        chk(pal_rd_en == 1'b0, "R1", {31'd0, pal_rd_en}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #(PERIOD/4);
        chk(m_valid == 1'b0, "R1", {31'd0, m_valid}, 32'd0);
        chk(s_ready == 1'b1, "R1", {31'd0, s_ready}, 32'd1);

        // R2 / R4: true colour, junk in the top byte and control low bits
        send(8'h11, 32'h00_112233, 32'h03_000000, "R2");
        send(8'h22, 32'hFF_A1B2C3, 32'h03_FFFFFF, "R4");
        send(8'h00, 32'h5A_000000, 32'h03_123456, "R4");
        // R3: other codes, boundary indices
        send(8'h00, 32'h00_ABCDEF, 32'h00_000000, "R3");
        send(8'hFF, 32'h00_ABCDEF, 32'h02_000003, "R3");
        send(8'h80, 32'h03_ABCDEF, 32'h04_000000, "R3");
        send(8'h7F, 32'h00_ABCDEF, 32'h83_000000, "R3");
        send(8'h01, 32'h00_ABCDEF, 32'hFF_FFFFFF, "R3");
        send(8'h40, 32'h00_ABCDEF, 32'h13_030303, "R3");
        idle();

        // R6: back-to-back with output always ready, no input wait expected
        wait_cycles = 0;
        for (int i = 0; i < 40; i++)
            send(8'(i * 7), {$urandom}, (i % 3 == 0) ? 32'h03_000000 : {8'(i), 24'h0}, "R6");
        chk(wait_cycles == 0, "R6", wait_cycles, 0);
        idle();

        // R7 / R8: random mix under random back-pressure
        stall_mode = 1'b1;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] c;
            c = {$urandom};
            if (i % 2 == 0) c[31:24] = 8'h03;
            send(8'($urandom), {$urandom}, c, "R8");
            if (i % 17 == 0) idle();
        end
        idle();
        stall_mode = 1'b0;
        repeat (6) @(negedge clk);
        #(PERIOD/4);
        chk(exp_q.size() == 0, "R8", exp_q.size(), 0);
        chk(m_valid == 1'b0, "R8", {31'd0, m_valid}, 32'd0);
        finish_run();
    end
endmodule